// File: doc/BRIEF.md
# Programmable DoS Packet Screen

This block looks at the parsed L3/L4 header fields of one packet per clock cycle. It decides whether the packet should be discarded as malformed or hostile. It does not parse headers. An upstream parser gives it a descriptor with these fields:

- IP version and the source and destination addresses
- protocol number
- fragment offset and the more-fragments flag
- TCP flags, sequence number and the TCP header length seen in a first fragment
- L4 ports
- ICMP type and ICMP payload length

Ten fixed sanity rules are evaluated in parallel. Each rule has its own enable bit, and a separate write port programs the ICMP size limit. One cycle after a descriptor is presented, the block reports three things: a drop flag, a reason mask with one bit for every enabled rule that matched, and the updated saturating hit counter of each rule. Forwarding logic uses the drop flag to discard the packet. Software watches the counters to see which attacks are present.

Top module: `dos_screen`

## Requirements
- R1: After reset every rule enable is 0, every counter is 0 and out_valid is 0. Until enables are written, no packet produces a drop or a reason bit.
- R2: out_valid, out_drop and out_reason appear exactly one cycle after pkt_valid. out_drop is the OR of out_reason. A cycle without pkt_valid gives out_valid, out_drop and out_reason all 0 one cycle later.
- R3: Reason bit 0 (address loop) is set when source equals destination. IPv6 packets (pkt_v6=1) compare all 128 bits. IPv4 packets compare only bits 31:0.
- R4: Reason bit 1 is set for TCP (protocol 6) when all six flag bits are zero and the sequence number is zero. Flag bits are FIN=0, SYN=1, RST=2, PSH=3, ACK=4, URG=5.
- R5: Reason bit 2 is set for TCP with FIN, PSH and URG all set and a sequence number of zero.
- R6: Reason bit 3 is set for TCP with both SYN and FIN set.
- R7: Reason bit 4 is set for TCP when source port equals destination port. Reason bit 5 does the same for UDP (protocol 17).
- R8: Reason bit 6 is set for a TCP first fragment (offset 0, more-fragments 1) whose TCP header length is below 20 bytes.
- R9: Reason bit 7 is set for TCP when the fragment offset equals 1.
- R10: ICMP is protocol 1 for IPv4 and protocol 58 for IPv6. Reason bit 8 is set for an ICMP echo request (type 8 for IPv4, type 128 for IPv6) whose payload length exceeds the programmed maximum. Reason bit 9 is set for any ICMP packet with more-fragments set or a nonzero offset.
- R11: A rule whose enable bit is 0 never sets its reason bit or advances its counter, whatever the packet.
- R12: Each rule has a CNT_W-bit counter. It increments by one for every reported reason bit of that rule and holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Descriptor present this cycle |
| pkt_v6 | input | 1 | 1 = IPv6, 0 = IPv4 |
| pkt_src | input | ADDR_W | Source address (IPv4 in bits 31:0) |
| pkt_dst | input | ADDR_W | Destination address (IPv4 in bits 31:0) |
| pkt_proto | input | 8 | IP protocol / next header |
| pkt_frag_off | input | 13 | Fragment offset |
| pkt_more_frag | input | 1 | More-fragments flag |
| pkt_tcp_flags | input | 6 | TCP flags, FIN in bit 0 to URG in bit 5 |
| pkt_seq | input | 32 | TCP sequence number |
| pkt_tcp_hlen | input | 8 | TCP header bytes present |
| pkt_sport | input | 16 | L4 source port |
| pkt_dport | input | 16 | L4 destination port |
| pkt_icmp_type | input | 8 | ICMP type |
| pkt_icmp_len | input | LEN_W | ICMP payload length |
| cfg_en_wr | input | 1 | Write strobe for rule enables |
| cfg_en_data | input | 10 | Rule enables, bit i = reason bit i |
| cfg_max_wr | input | 1 | Write strobe for ICMP limit |
| cfg_max_data | input | LEN_W | ICMP payload limit |
| out_valid | output | 1 | Decision present |
| out_drop | output | 1 | Discard the packet |
| out_reason | output | 10 | Matched enabled rules |
| match_cnt | output | 10*CNT_W | Counter of rule i in bits i*CNT_W +: CNT_W |

## Verification
A stuck or wrongly written enable bit shows on the very next descriptor: that rule's reason bit is missing, or the bit appears under a disabled rule. A rule decode that fires on the wrong protocol, flag or fragment combination shows one cycle after the offending descriptor as an unexpected or missing reason bit. The bench therefore sweeps every flag value across several protocols, port relations and fragment cases, under full, partial and empty enable masks. A counter that misses a hit or wraps instead of holding shows only as a value difference, checked after each sweep once many hits have accumulated past saturation.

// File: rtl/dos_screen.sv
module dos_screen #(
  parameter int ADDR_W = 128,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16,
  localparam int NCHK  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  input  logic                  pkt_v6,
  input  logic [ADDR_W-1:0]     pkt_src,
  input  logic [ADDR_W-1:0]     pkt_dst,
  input  logic [7:0]            pkt_proto,
  input  logic [12:0]           pkt_frag_off,
  input  logic                  pkt_more_frag,
  input  logic [5:0]            pkt_tcp_flags,
  input  logic [31:0]           pkt_seq,
  input  logic [7:0]            pkt_tcp_hlen,
  input  logic [15:0]           pkt_sport,
  input  logic [15:0]           pkt_dport,
  input  logic [7:0]            pkt_icmp_type,
  input  logic [LEN_W-1:0]      pkt_icmp_len,
  input  logic                  cfg_en_wr,
  input  logic [NCHK-1:0]       cfg_en_data,
  input  logic                  cfg_max_wr,
  input  logic [LEN_W-1:0]      cfg_max_data,
  output logic                  out_valid,
  output logic                  out_drop,
  output logic [NCHK-1:0]       out_reason,
  output logic [NCHK*CNT_W-1:0] match_cnt
);

  localparam logic [7:0] PROTO_TCP   = 8'd6;
  localparam logic [7:0] PROTO_UDP   = 8'd17;
  localparam logic [7:0] PROTO_ICMP4 = 8'd1;
  localparam logic [7:0] PROTO_ICMP6 = 8'd58;
  localparam int FIN = 0, SYN = 1, PSH = 3, URG = 5;

  logic [NCHK-1:0]  en_q;
  logic [LEN_W-1:0] icmp_max_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      icmp_max_q <= '0;
    end else begin
      if (cfg_en_wr)  en_q       <= cfg_en_data;
      if (cfg_max_wr) icmp_max_q <= cfg_max_data;
    end
  end

  wire is_tcp     = pkt_proto == PROTO_TCP;
  wire is_udp     = pkt_proto == PROTO_UDP;
  wire is_icmp    = pkt_proto == (pkt_v6 ? PROTO_ICMP6 : PROTO_ICMP4);
  wire seq_zero   = pkt_seq == 32'd0;
  wire ports_eq   = pkt_sport == pkt_dport;
  wire fragmented = pkt_more_frag || (pkt_frag_off != 13'd0);
  wire first_frag = pkt_more_frag && (pkt_frag_off == 13'd0);
  wire addr_eq    = pkt_v6 ? (pkt_src == pkt_dst) : (pkt_src[31:0] == pkt_dst[31:0]);
  wire is_echo    = pkt_v6 ? (pkt_icmp_type == 8'd128) : (pkt_icmp_type == 8'd8);

  logic [NCHK-1:0] hit, fired;

  always_comb begin
    hit[0] = addr_eq;
    hit[1] = is_tcp && (pkt_tcp_flags == 6'd0) && seq_zero;
    hit[2] = is_tcp && pkt_tcp_flags[FIN] && pkt_tcp_flags[PSH] && pkt_tcp_flags[URG] && seq_zero;
    hit[3] = is_tcp && pkt_tcp_flags[SYN] && pkt_tcp_flags[FIN];
    hit[4] = is_tcp && ports_eq;
    hit[5] = is_udp && ports_eq;
    hit[6] = is_tcp && first_frag && (pkt_tcp_hlen < 8'd20);
    hit[7] = is_tcp && (pkt_frag_off == 13'd1);
    hit[8] = is_icmp && is_echo && (pkt_icmp_len > icmp_max_q);
    hit[9] = is_icmp && fragmented;
  end

  assign fired = hit & en_q & {NCHK{pkt_valid}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_drop   <= 1'b0;
      out_reason <= '0;
    end else begin
      out_valid  <= pkt_valid;
      out_drop   <= |fired;
      out_reason <= fired;
    end
  end

  for (genvar i = 0; i < NCHK; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (fired[i] && (cnt_q != {CNT_W{1'b1}}))
        cnt_q <= cnt_q + 1'b1;
    end
    assign match_cnt[i*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/dos_screen_chk.sv
module dos_screen_chk #(
  parameter int ADDR_W = 128,
  parameter int CW     = 16,
  parameter int NCHK   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_valid,
  input logic               pkt_v6,
  input logic [ADDR_W-1:0]  pkt_src,
  input logic [ADDR_W-1:0]  pkt_dst,
  input logic [7:0]         pkt_proto,
  input logic [5:0]         pkt_tcp_flags,
  input logic [NCHK-1:0]    en_q,
  input logic               out_valid,
  input logic               out_drop,
  input logic [NCHK-1:0]    out_reason,
  input logic [NCHK*CW-1:0] match_cnt
);

  assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (!out_valid && !out_drop && out_reason == '0));

  assert_land_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && en_q[0] && !pkt_v6 && pkt_src[31:0] == pkt_dst[31:0]) |=> out_reason[0]);

  assert_synfin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && en_q[3] && pkt_proto == 8'd6 && pkt_tcp_flags[0] && pkt_tcp_flags[1]) |=> out_reason[3]);

  assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> ((out_reason & ~$past(en_q)) == '0));

  assert_cnt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_reason[0] |-> $stable(match_cnt[CW-1:0]) or $past(!rst_n));

endmodule

bind dos_screen dos_screen_chk #(.ADDR_W(ADDR_W), .CW(CNT_W), .NCHK(10)) chk_i (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_v6(pkt_v6),
  .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pkt_proto(pkt_proto),
  .pkt_tcp_flags(pkt_tcp_flags), .en_q(en_q), .out_valid(out_valid),
  .out_drop(out_drop), .out_reason(out_reason), .match_cnt(match_cnt)
);

// File: tb/dos_screen_tb_top.sv
module dos_screen_tb_top;
  localparam int CW = 8;
  localparam int NC = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic pkt_valid = 0, pkt_v6 = 0, pkt_more_frag = 0;
  logic [127:0] pkt_src = '0, pkt_dst = '0;
  logic [7:0] pkt_proto = 0, pkt_tcp_hlen = 0, pkt_icmp_type = 0;
  logic [12:0] pkt_frag_off = 0;
  logic [5:0] pkt_tcp_flags = 0;
  logic [31:0] pkt_seq = 0;
  logic [15:0] pkt_sport = 0, pkt_dport = 0, pkt_icmp_len = 0;
  logic cfg_en_wr = 0, cfg_max_wr = 0;
  logic [NC-1:0] cfg_en_data = 0;
  logic [15:0] cfg_max_data = 0;
  logic out_valid, out_drop;
  logic [NC-1:0] out_reason;
  logic [NC*CW-1:0] match_cnt;

  dos_screen #(.ADDR_W(128), .LEN_W(16), .CNT_W(CW)) dut_i (.*);

  int checks = 0, failures = 0;
  int exp_cnt[NC];
  logic [NC-1:0] en_m = '0;
  logic [15:0] max_m = '0;
  string tag[NC] = '{"R3","R4","R5","R6","R7","R7","R8","R9","R10","R10"};

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] model();
    logic [NC-1:0] h;
    logic tcp, udp, icmp, echo;
    tcp  = pkt_proto == 8'd6;
    udp  = pkt_proto == 8'd17;
    icmp = pkt_v6 ? pkt_proto == 8'd58 : pkt_proto == 8'd1;
    echo = pkt_v6 ? pkt_icmp_type == 8'd128 : pkt_icmp_type == 8'd8;
    h[0] = pkt_v6 ? pkt_src == pkt_dst : pkt_src[31:0] == pkt_dst[31:0];
    h[1] = tcp && pkt_tcp_flags == 0 && pkt_seq == 0;
    h[2] = tcp && pkt_tcp_flags[0] && pkt_tcp_flags[3] && pkt_tcp_flags[5] && pkt_seq == 0;
    h[3] = tcp && pkt_tcp_flags[0] && pkt_tcp_flags[1];
    h[4] = tcp && pkt_sport == pkt_dport;
    h[5] = udp && pkt_sport == pkt_dport;
    h[6] = tcp && pkt_frag_off == 0 && pkt_more_frag && pkt_tcp_hlen < 20;
    h[7] = tcp && pkt_frag_off == 1;
    h[8] = icmp && echo && pkt_icmp_len > max_m;
    h[9] = icmp && (pkt_more_frag || pkt_frag_off != 0);
    return h & en_m;
  endfunction

  task automatic send();
    logic [NC-1:0] e;
    string req;
    pkt_valid = 1'b1;
    e = model();
    @(negedge clk);
    check("R2 valid", out_valid, 1);
    check("R2 drop", out_drop, |e);
    req = "R2";
    for (int i = 0; i < NC; i++)
      if (out_reason[i] !== e[i]) req = en_m[i] ? tag[i] : "R11";
    check(req, out_reason, e);
    for (int i = 0; i < NC; i++)
      if (e[i] && exp_cnt[i] < (1 << CW) - 1) exp_cnt[i]++;
  endtask

  task automatic idle();
    pkt_valid = 1'b0;
    @(negedge clk);
    check("R2 idle valid", out_valid, 0);
    check("R2 idle reason", {out_drop, out_reason}, 0);
  endtask

  task automatic write_cfg(logic [NC-1:0] en, logic [15:0] mx);
    cfg_en_wr = 1; cfg_en_data = en; cfg_max_wr = 1; cfg_max_data = mx;
    @(negedge clk);
    cfg_en_wr = 0; cfg_max_wr = 0;
    en_m = en; max_m = mx;
  endtask

  task automatic cmp_cnt();
    for (int i = 0; i < NC; i++)
      check("R12 counter", match_cnt[i*CW +: CW], exp_cnt[i]);
  endtask

  task automatic sweep();
    logic [7:0] protos[5] = '{8'd1, 8'd6, 8'd17, 8'd58, 8'd50};
    for (int p = 0; p < 5; p++)
      for (int f = 0; f < 64; f++)
        for (int s = 0; s < 2; s++)
          for (int pe = 0; pe < 2; pe++)
            for (int fc = 0; fc < 4; fc++) begin
              pkt_proto = protos[p];
              pkt_tcp_flags = 6'(f);
              pkt_v6 = f[5];
              pkt_seq = s ? 32'd5 : 32'd0;
              pkt_sport = 16'd1000;
              pkt_dport = pe ? 16'd1000 : 16'd1001;
              pkt_src = {96'hfe80_0000_1111_2222_3333_4444, 32'h0a00_0001};
              pkt_dst = pe ? pkt_src : pkt_src ^ 128'd1;
              case (f[1:0])
                2'd0: pkt_icmp_type = 8'd0;
                2'd1: pkt_icmp_type = 8'd8;
                2'd2: pkt_icmp_type = 8'd128;
                default: pkt_icmp_type = 8'd3;
              endcase
              pkt_icmp_len = 16'd98 + 16'(f[3:2]);
              pkt_tcp_hlen = f[2] ? 8'd20 : 8'd19;
              pkt_frag_off = (fc == 2) ? 13'd1 : (fc == 3) ? 13'd5 : 13'd0;
              pkt_more_frag = (fc == 1) || (fc == 3);
              send();
            end
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", out_valid, 0);
    check("R1 reset reason", {out_drop, out_reason}, 0);
    check("R1 reset counters", match_cnt, 0);

    pkt_proto = 8'd6; pkt_tcp_flags = 6'h03; pkt_sport = 7; pkt_dport = 7;
    pkt_src = 1; pkt_dst = 1; pkt_v6 = 0;
    pkt_valid = 1;
    @(negedge clk);
    check("R1 disabled after reset", {out_drop, out_reason}, 0);
    idle();
    check("R1 counters unchanged", match_cnt, 0);

    write_cfg('1, 16'd100);
    pkt_proto = 8'd50; pkt_sport = 1; pkt_dport = 2;
    pkt_v6 = 0; pkt_src = {96'h1, 32'hc0a8_0001}; pkt_dst = {96'h2, 32'hc0a8_0001}; send();
    pkt_v6 = 0; pkt_dst = {96'h1, 32'hc0a8_0002}; send();
    pkt_v6 = 1; pkt_dst = {96'h2, 32'hc0a8_0001}; send();
    pkt_v6 = 1; pkt_dst = pkt_src; send();
    pkt_v6 = 0; pkt_proto = 8'd1; pkt_icmp_type = 8'd8; pkt_more_frag = 0; pkt_frag_off = 0;
    pkt_dst = pkt_src ^ 128'd4;
    pkt_icmp_len = 16'd100; send();
    pkt_icmp_len = 16'd101; send();
    idle();
    write_cfg('1, 16'd0);
    pkt_icmp_len = 16'd1; send();
    pkt_icmp_len = 16'd0; send();
    idle();
    cmp_cnt();

    write_cfg('1, 16'd100);
    sweep();
    cmp_cnt();
    write_cfg(10'h155, 16'd100);
    sweep();
    cmp_cnt();
    write_cfg(10'h2aa, 16'd99);
    sweep();
    cmp_cnt();
    write_cfg('0, 16'd99);
    sweep();
    cmp_cnt();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule